// File: doc/BRIEF.md
# Two-Step Combination Lock Controller

This block is the control logic of a door lock opened by dialling two 2-bit values in turn. The user sets the code switches to the first secret value and presses the enter button. Then the user sets the second secret value and presses enter again. The lock releases on the second press. Any mismatch latches a fault indication, and only a reset press clears it.

The two secret values are parameters. Two small comparators reduce the code bus to two hit flags, one for each secret value. A Mealy state machine consumes only those flags, so changing the combination leaves the sequencing logic untouched. Both outputs depend on the present state and on the current inputs, so the release and the fault appear in the same cycle as the enter pulse that causes them.

The state register is 3 bits wide and has an asynchronous clear that drives every bit to zero. The all-zero code is the idle state.

Top module: `seq_lock_ctrl`

## Requirements
- R1: While `aclr` is high, the state is forced to idle (3'b000) at once, without waiting for a clock edge. With `rst` low and `enter` low, both `unlock` and `fault` read 0 while the clear is held and after it is released.
- R2: In idle, an `enter` pulse with `code` equal to `KEY_A` advances to the armed state (3'b001). Neither output is raised in that cycle.
- R3: In the armed state, an `enter` pulse with `code` equal to `KEY_B` raises `unlock` in that same cycle and moves to the open state (3'b010). There, `unlock` stays 1 on every cycle until reset.
- R4: While `enter` is low, the state does not change, whatever `code` shows. Any number of idle cycles may separate the two presses.
- R5: In idle, an `enter` pulse with `code` not equal to `KEY_A` raises `fault` in that cycle and moves to the error state (3'b011). There, `fault` stays 1 on every cycle until reset.
- R6: In the armed state, an `enter` pulse with `code` not equal to `KEY_B` raises `fault` in that cycle and moves to the error state.
- R7: While `rst` is 1, `unlock` and `fault` are both 0 in every state. The next state is idle. `rst` wins over `enter` in the same cycle.
- R8: In the open and error states, `enter` pulses are ignored, whatever `code` shows. The output already raised stays 1 and the other output stays 0.
- R9: `unlock` and `fault` are never 1 at the same time. The unused state codes 3'b100 to 3'b111 lead to the error state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| aclr | input | 1 | Asynchronous clear of the state register, active high |
| rst | input | 1 | Synchronous reset button, active high |
| enter | input | 1 | Enter strobe, high for one cycle per press |
| code | input | CODE_W | Code switch setting |
| unlock | output | 1 | Release command (Mealy) |
| fault | output | 1 | Error light (Mealy) |

## Verification
The bench builds the block with `KEY_A = 2'b10` and `KEY_B = 2'b01` instead of the defaults. A decode that compared against fixed constants, or that swapped the two keys, would then fail on the first press. The random stream draws all four code values on every press. This reaches every wrong-first and wrong-second combination, resets in each of the four states, and presses in the open and error states. An asynchronous clear asserted between clock edges while the lock is open confirms that the clear does not wait for the clock.

// File: rtl/seq_lock_ctrl.sv
`timescale 1ns/1ps
module seq_lock_ctrl #(
  parameter int CODE_W = 2,
  parameter logic [CODE_W-1:0] KEY_A = 2'b01,
  parameter logic [CODE_W-1:0] KEY_B = 2'b11
) (
  input  logic              clk,
  input  logic              aclr,
  input  logic              rst,
  input  logic              enter,
  input  logic [CODE_W-1:0] code,
  output logic              unlock,
  output logic              fault
);
  localparam int ST_W = 3;
  localparam logic [ST_W-1:0] S_IDLE = 3'd0;
  localparam logic [ST_W-1:0] S_ARM  = 3'd1;
  localparam logic [ST_W-1:0] S_OPEN = 3'd2;
  localparam logic [ST_W-1:0] S_ERR  = 3'd3;

  logic [ST_W-1:0] st, st_nx;
  logic hit_a, hit_b;

  assign hit_a = (code == KEY_A);
  assign hit_b = (code == KEY_B);

  always_comb begin
    st_nx = st;
    if (rst) st_nx = S_IDLE;
    else begin
      case (st)
        S_IDLE:  if (enter) st_nx = hit_a ? S_ARM : S_ERR;
        S_ARM:   if (enter) st_nx = hit_b ? S_OPEN : S_ERR;
        S_OPEN:  st_nx = S_OPEN;
        S_ERR:   st_nx = S_ERR;
        default: st_nx = S_ERR;
      endcase
    end
  end

  always_ff @(posedge clk or posedge aclr)
    if (aclr) st <= S_IDLE;
    else      st <= st_nx;

  assign unlock = !rst && ((st == S_OPEN) || (st == S_ARM && enter && hit_b));
  assign fault  = !rst && ((st == S_ERR) || (st[2]) ||
                           (st == S_IDLE && enter && !hit_a) ||
                           (st == S_ARM  && enter && !hit_b));

  p_rst_to_idle_r7: assert property (@(posedge clk) disable iff (aclr)
    rst |=> (st == S_IDLE));
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (aclr)
    (!rst && !enter && !st[2]) |=> $stable(st));
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (aclr)
    (!rst && st == S_ERR) |=> (st == S_ERR));
  p_open_sticky_r8: assert property (@(posedge clk) disable iff (aclr)
    (!rst && st == S_OPEN) |=> (st == S_OPEN));
  p_unlock_to_open_r3: assert property (@(posedge clk) disable iff (aclr)
    unlock |=> (st == S_OPEN));
  p_arm_step_r2: assert property (@(posedge clk) disable iff (aclr)
    (!rst && enter && hit_a && st == S_IDLE) |=> (st == S_ARM));
  p_excl_r9: assert property (@(posedge clk) disable iff (aclr)
    !(unlock && fault));
  p_fault_to_err_r6: assert property (@(posedge clk) disable iff (aclr)
    fault |=> (st == S_ERR));
endmodule

// File: tb/sim_seq_lock_ctrl.sv
`timescale 1ns/1ps
module sim_seq_lock_ctrl;
  localparam logic [1:0] KA = 2'b10;
  localparam logic [1:0] KB = 2'b01;
  localparam logic [1:0] KX = 2'b11;

  logic clk = 0, aclr = 1, rst = 0, enter = 0;
  logic [1:0] code = 0;
  logic unlock, fault;
  int checks = 0, errs = 0;
  int m_st = 0;

  always #5 clk = ~clk;

  seq_lock_ctrl #(.CODE_W(2), .KEY_A(KA), .KEY_B(KB)) u0 (
    .clk(clk), .aclr(aclr), .rst(rst), .enter(enter), .code(code),
    .unlock(unlock), .fault(fault));

  function automatic bit f_unl(int s, bit r, bit e, logic [1:0] c);
    return !r && (s == 2 || (s == 1 && e && c == KB));
  endfunction
  function automatic bit f_flt(int s, bit r, bit e, logic [1:0] c);
    return !r && (s == 3 || (s == 0 && e && c != KA) || (s == 1 && e && c != KB));
  endfunction
  function automatic int f_nx(int s, bit r, bit e, logic [1:0] c);
    if (r) return 0;
    if (!e) return s;
    if (s == 0) return (c == KA) ? 1 : 3;
    if (s == 1) return (c == KB) ? 2 : 3;
    return s;
  endfunction

  task automatic chk(string tag, bit eu, bit ef);
    checks++;
    if (unlock !== eu || fault !== ef) begin
      errs++;
      $display("FAIL %s unlock/fault got %b%b exp %b%b", tag, unlock, fault, eu, ef);
    end
  endtask

  task automatic step(bit r, bit e, logic [1:0] c, string tag);
    @(negedge clk);
    rst = r; enter = e; code = c;
    #1;
    chk(tag, f_unl(m_st, r, e, c), f_flt(m_st, r, e, c));
    m_st = f_nx(m_st, r, e, c);
  endtask

  initial begin
    #2000000;
    errs++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    #1; chk("R1 during clear", 0, 0);
    repeat (2) @(negedge clk);
    aclr = 0; m_st = 0;
    step(0, 0, KB, "R1 after clear");
    // R2 then R4 idle gap then R3
    step(0, 1, KA, "R2 first value");
    step(0, 0, KB, "R4 idle");
    step(0, 0, KX, "R4 idle");
    step(0, 0, KA, "R4 idle");
    step(0, 1, KB, "R3 second value");
    step(0, 0, KX, "R3 open held");
    step(0, 1, KX, "R8 enter in open");
    step(0, 1, KA, "R8 enter in open");
    step(1, 1, KA, "R7 reset over enter");
    // R5 wrong first
    step(0, 1, KB, "R5 wrong first");
    step(0, 0, KA, "R5 sticky");
    step(0, 1, KA, "R8 enter in error");
    step(1, 0, KA, "R7 reset in error");
    // R6 wrong second
    step(0, 1, KA, "R2 first value");
    step(0, 1, KX, "R6 wrong second");
    step(0, 0, KB, "R6 sticky");
    step(1, 0, KB, "R7 reset");
    // both wrong
    step(0, 1, KX, "R5 both wrong first");
    step(0, 1, KX, "R8 both wrong second");
    step(1, 0, 0, "R7 reset");
    // reset after correct first
    step(0, 1, KA, "R2 first value");
    step(1, 1, KB, "R7 reset after first");
    step(0, 1, KB, "R5 restart from idle");
    step(1, 0, 0, "R7 reset");
    // async clear while open
    step(0, 1, KA, "R2 first value");
    step(0, 1, KB, "R3 second value");
    @(negedge clk); rst = 0; enter = 0; #2;
    aclr = 1; #1;
    chk("R1 async clear while open", 0, 0);
    m_st = 0;
    @(negedge clk); aclr = 0;
    step(0, 0, KA, "R1 idle after clear");
    // random
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      bit r, e;
      logic [1:0] c;
      string t;
      r = ($urandom % 16) == 0;
      e = ($urandom % 3) == 0;
      c = 2'($urandom % 4);
      if (r) t = "R7 random";
      else if (!e) t = "R4 random";
      else if (m_st == 0) t = "R2 random";
      else if (m_st == 1) t = "R3 random";
      else t = "R8 random";
      step(r, e, c, t);
      if (unlock && fault) begin
        checks++; errs++;
        $display("FAIL R9 both high got 11 exp not 11");
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule